// File: doc/BRIEF.md
# In-Order Memory Address Queue

This block sits between dispatch and the data-memory path of an out-of-order core. Each load or store from dispatch is written into a circular queue together with the tag of its base register, the tag of its store data (stores only), a signed immediate offset and the tag of the register a load will write. Operands that are not ready at dispatch become ready when a result broadcast carrying their tag arrives, and the base value travels with that broadcast.

Memory operations leave the queue strictly in program order, one per cycle at most. A departing operation spends one cycle in an address stage, where base plus sign-extended offset is formed, and one cycle in a lookup stage, where a single request combines translation and data-cache access. During the address cycle of a load the block raises a speculative wakeup with the load's destination tag, so the integer scheduler can issue a consumer during the lookup cycle and that consumer picks up the data from the bypass a cycle later. When the lookup reports a miss, a registered miss flag tells the scheduler to replay those consumers. When the lookup port is not ready, the whole memory pipeline holds and issue stops.

Top module: `mem_order_queue`

## Requirements
- R1: When `disp_valid` is high and `disp_stall` is low at a clock edge, the operation is written at the tail of the queue. `disp_stall` is high exactly when DEPTH operations are queued, and a dispatch offered while `disp_stall` is high is dropped and never reaches the lookup port.
- R2: Only the oldest queued operation may issue; younger operations with all operands ready wait behind an oldest one whose operands are not ready, and results leave in dispatch order.
- R3: The oldest entry issues when its base operand is ready; a store (`disp_store` = 1; 0 means load) also needs its data operand ready. At most one operation issues per cycle.
- R4: A broadcast (`bc_valid` high) whose `bc_tag` equals a pending operand tag marks that operand ready from the next cycle and, for a base operand, captures `bc_value`. This also applies to an operation dispatched in the same cycle as the broadcast.
- R5: The lookup address is the base value plus the offset sign-extended from OFS_W bits, modulo 2^DATA_W. An operation that issues in cycle c is in the address stage in cycle c+1 and drives `lk_req`, `lk_addr` and `lk_store` in cycle c+2.
- R6: `wake_valid` is high, with `wake_tag` equal to the load's destination tag, in the cycle a load sits in the address stage and the pipeline is not held; the next cycle that load is presented to the lookup port. Stores never raise it.
- R7: A lookup completes in a cycle with `lk_req` and `lk_ready` both high; in the next cycle `res_valid` pulses for one cycle with `res_hit`, `res_data` equal to the sampled `lk_hit` and `lk_data`, `res_tag` the destination tag and `res_store` the kind.
- R8: `miss_valid` is high together with `res_valid` exactly when a load completed with `lk_hit` low; a store that misses never raises it.
- R9: While `lk_req` is high and `lk_ready` low, `lk_addr` and `lk_store` stay unchanged, the address stage keeps its operation, no new operation issues and `wake_valid` stays low.
- R10: After reset the queue is empty: `disp_stall`, `lk_req`, `wake_valid`, `res_valid` and `miss_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch offers an operation |
| disp_store | input | 1 | 1 = store, 0 = load |
| disp_base_tag | input | TAG_W | Tag of the base register |
| disp_base_rdy | input | 1 | Base value already available |
| disp_base_val | input | DATA_W | Base value when ready |
| disp_data_tag | input | TAG_W | Tag of the store data register |
| disp_data_rdy | input | 1 | Store data already available |
| disp_offset | input | OFS_W | Signed immediate offset |
| disp_dst_tag | input | TAG_W | Destination tag of a load (identifier of a store) |
| disp_stall | output | 1 | Queue full, dispatch must wait |
| bc_valid | input | 1 | Result broadcast valid |
| bc_tag | input | TAG_W | Broadcast result tag |
| bc_value | input | DATA_W | Broadcast result value |
| wake_valid | output | 1 | Speculative wakeup for load consumers |
| wake_tag | output | TAG_W | Destination tag being woken |
| lk_req | output | 1 | Lookup request |
| lk_addr | output | DATA_W | Lookup address |
| lk_store | output | 1 | Lookup is for a store |
| lk_ready | input | 1 | Lookup port accepts the request this cycle |
| lk_hit | input | 1 | Lookup hit |
| lk_data | input | DATA_W | Lookup read data |
| res_valid | output | 1 | Completed operation |
| res_store | output | 1 | Completed operation was a store |
| res_hit | output | 1 | Completed lookup hit |
| res_data | output | DATA_W | Loaded data |
| res_tag | output | TAG_W | Destination tag of completed operation |
| miss_valid | output | 1 | Load miss, replay its consumers |

## Verification
The bench builds the block with DEPTH = 4, TAG_W = 4, DATA_W = 16 and OFS_W = 8. The small depth lets four dispatches fill the queue so the stall, the dropped extra dispatch and the in-order release behind a blocked oldest entry are reached within a few cycles. The 16-bit data path with 8-bit offsets makes address wrap-around and negative offsets easy to hit with short literal vectors.

// File: rtl/moq_pkg.sv
package moq_pkg;

    typedef enum logic {
        OP_LOAD  = 1'b0,
        OP_STORE = 1'b1
    } mem_op_e;

endpackage

// File: rtl/moq_agu.sv
module moq_agu #(
    parameter int DATA_W = 32,
    parameter int OFS_W  = 12
) (
    input  logic [DATA_W-1:0] base_val,
    input  logic [OFS_W-1:0]  offset,
    output logic [DATA_W-1:0] eff_addr
);
    localparam int EXT_W = DATA_W - OFS_W;

    logic [DATA_W-1:0] ofs_ext;

    always_comb begin
        ofs_ext  = {{EXT_W{offset[OFS_W-1]}}, offset};
        eff_addr = base_val + ofs_ext;
    end

endmodule

// File: rtl/moq_ring.sv
module moq_ring
    import moq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 32,
    parameter int OFS_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  mem_op_e           push_op,
    input  logic [TAG_W-1:0]  push_btag,
    input  logic              push_brdy,
    input  logic [DATA_W-1:0] push_bval,
    input  logic [TAG_W-1:0]  push_dtag,
    input  logic              push_drdy,
    input  logic [OFS_W-1:0]  push_ofs,
    input  logic [TAG_W-1:0]  push_dst,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_val,
    input  logic              pop,
    output logic              full,
    output logic              head_go,
    output mem_op_e           head_op,
    output logic [DATA_W-1:0] head_bval,
    output logic [OFS_W-1:0]  head_ofs,
    output logic [TAG_W-1:0]  head_dst
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    typedef struct packed {
        logic              vld;
        mem_op_e           op;
        logic [TAG_W-1:0]  btag;
        logic              brdy;
        logic [DATA_W-1:0] bval;
        logic [TAG_W-1:0]  dtag;
        logic              drdy;
        logic [OFS_W-1:0]  ofs;
        logic [TAG_W-1:0]  dst;
    } slot_t;

    typedef struct packed {
        logic [PTR_W-1:0] head;
        logic [PTR_W-1:0] tail;
        logic [CNT_W-1:0] cnt;
    } ptr_t;

    slot_t slot_q [DEPTH];
    slot_t slot_d [DEPTH];
    ptr_t  ptr_q, ptr_d;

    logic [DEPTH-1:0] base_hit;
    logic [DEPTH-1:0] data_hit;
    logic             push_base_ok;
    logic             push_data_ok;
    logic [DATA_W-1:0] push_base_v;

    // per-slot broadcast match
    for (genvar g = 0; g < DEPTH; g++) begin : g_match
        assign base_hit[g] = bc_valid && slot_q[g].vld && !slot_q[g].brdy
                             && (slot_q[g].btag == bc_tag);
        assign data_hit[g] = bc_valid && slot_q[g].vld && !slot_q[g].drdy
                             && (slot_q[g].dtag == bc_tag);
    end

    // same-cycle broadcast seen by an incoming operation
    always_comb begin
        push_base_ok = push_brdy || (bc_valid && (bc_tag == push_btag));
        push_base_v  = push_brdy ? push_bval : bc_val;
        push_data_ok = (push_op == OP_LOAD) || push_drdy
                       || (bc_valid && (bc_tag == push_dtag));
    end

    always_comb begin
        slot_d = slot_q;
        ptr_d  = ptr_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (base_hit[i]) begin
                slot_d[i].brdy = 1'b1;
                slot_d[i].bval = bc_val;
            end
            if (data_hit[i]) begin
                slot_d[i].drdy = 1'b1;
            end
            if (pop && (ptr_q.head == PTR_W'(i))) begin
                slot_d[i].vld = 1'b0;
            end
            if (push && (ptr_q.tail == PTR_W'(i))) begin
                slot_d[i].vld  = 1'b1;
                slot_d[i].op   = push_op;
                slot_d[i].btag = push_btag;
                slot_d[i].brdy = push_base_ok;
                slot_d[i].bval = push_base_v;
                slot_d[i].dtag = push_dtag;
                slot_d[i].drdy = push_data_ok;
                slot_d[i].ofs  = push_ofs;
                slot_d[i].dst  = push_dst;
            end
        end
        if (pop) begin
            ptr_d.head = (ptr_q.head == LAST_IDX) ? '0 : ptr_q.head + 1'b1;
        end
        if (push) begin
            ptr_d.tail = (ptr_q.tail == LAST_IDX) ? '0 : ptr_q.tail + 1'b1;
        end
        ptr_d.cnt = ptr_q.cnt + CNT_W'(push) - CNT_W'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                slot_q[i] <= '0;
            end
        end else begin
            ptr_q <= ptr_d;
            for (int i = 0; i < DEPTH; i++) begin
                slot_q[i] <= slot_d[i];
            end
        end
    end

    always_comb begin
        full      = (ptr_q.cnt == FULL_CNT);
        head_op   = slot_q[ptr_q.head].op;
        head_bval = slot_q[ptr_q.head].bval;
        head_ofs  = slot_q[ptr_q.head].ofs;
        head_dst  = slot_q[ptr_q.head].dst;
        head_go   = slot_q[ptr_q.head].vld && slot_q[ptr_q.head].brdy
                    && ((slot_q[ptr_q.head].op == OP_LOAD) || slot_q[ptr_q.head].drdy);
    end

endmodule

// File: rtl/moq_pipe.sv
module moq_pipe
    import moq_pkg::*;
#(
    parameter int TAG_W  = 6,
    parameter int DATA_W = 32,
    parameter int OFS_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_req,
    input  mem_op_e           iss_op,
    input  logic [DATA_W-1:0] iss_bval,
    input  logic [OFS_W-1:0]  iss_ofs,
    input  logic [TAG_W-1:0]  iss_dst,
    output logic              iss_take,
    output logic              hold,
    output logic              wake_valid,
    output logic [TAG_W-1:0]  wake_tag,
    output logic              lk_req,
    output logic [DATA_W-1:0] lk_addr,
    output logic              lk_store,
    input  logic              lk_ready,
    input  logic              lk_hit,
    input  logic [DATA_W-1:0] lk_data,
    output logic              res_valid,
    output logic              res_store,
    output logic              res_hit,
    output logic [DATA_W-1:0] res_data,
    output logic [TAG_W-1:0]  res_tag,
    output logic              miss_valid
);
    typedef struct packed {
        logic              s1_vld;
        mem_op_e           s1_op;
        logic [DATA_W-1:0] s1_bval;
        logic [OFS_W-1:0]  s1_ofs;
        logic [TAG_W-1:0]  s1_dst;
        logic              s2_vld;
        mem_op_e           s2_op;
        logic [DATA_W-1:0] s2_addr;
        logic [TAG_W-1:0]  s2_dst;
        logic              r_vld;
        mem_op_e           r_op;
        logic              r_hit;
        logic [DATA_W-1:0] r_data;
        logic [TAG_W-1:0]  r_dst;
    } stage_t;

    stage_t st_q, st_d;
    logic [DATA_W-1:0] s1_addr;

    moq_agu #(
        .DATA_W (DATA_W),
        .OFS_W  (OFS_W)
    ) u_agu (
        .base_val (st_q.s1_bval),
        .offset   (st_q.s1_ofs),
        .eff_addr (s1_addr)
    );

    always_comb begin
        hold     = st_q.s2_vld && !lk_ready;
        iss_take = iss_req && !hold;
        st_d     = st_q;

        // lookup stage completes into the result register
        st_d.r_vld = st_q.s2_vld && lk_ready;
        if (st_q.s2_vld && lk_ready) begin
            st_d.r_op   = st_q.s2_op;
            st_d.r_hit  = lk_hit;
            st_d.r_data = lk_data;
            st_d.r_dst  = st_q.s2_dst;
        end

        if (!hold) begin
            st_d.s2_vld  = st_q.s1_vld;
            st_d.s2_op   = st_q.s1_op;
            st_d.s2_addr = s1_addr;
            st_d.s2_dst  = st_q.s1_dst;
            st_d.s1_vld  = iss_take;
            if (iss_take) begin
                st_d.s1_op   = iss_op;
                st_d.s1_bval = iss_bval;
                st_d.s1_ofs  = iss_ofs;
                st_d.s1_dst  = iss_dst;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        wake_valid = st_q.s1_vld && (st_q.s1_op == OP_LOAD) && !hold;
        wake_tag   = st_q.s1_dst;
        lk_req     = st_q.s2_vld;
        lk_addr    = st_q.s2_addr;
        lk_store   = (st_q.s2_op == OP_STORE);
        res_valid  = st_q.r_vld;
        res_store  = (st_q.r_op == OP_STORE);
        res_hit    = st_q.r_hit;
        res_data   = st_q.r_data;
        res_tag    = st_q.r_dst;
        miss_valid = st_q.r_vld && (st_q.r_op == OP_LOAD) && !st_q.r_hit;
    end

endmodule

// File: rtl/mem_order_queue.sv
module mem_order_queue
    import moq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 32,
    parameter int OFS_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_valid,
    input  logic              disp_store,
    input  logic [TAG_W-1:0]  disp_base_tag,
    input  logic              disp_base_rdy,
    input  logic [DATA_W-1:0] disp_base_val,
    input  logic [TAG_W-1:0]  disp_data_tag,
    input  logic              disp_data_rdy,
    input  logic [OFS_W-1:0]  disp_offset,
    input  logic [TAG_W-1:0]  disp_dst_tag,
    output logic              disp_stall,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_value,
    output logic              wake_valid,
    output logic [TAG_W-1:0]  wake_tag,
    output logic              lk_req,
    output logic [DATA_W-1:0] lk_addr,
    output logic              lk_store,
    input  logic              lk_ready,
    input  logic              lk_hit,
    input  logic [DATA_W-1:0] lk_data,
    output logic              res_valid,
    output logic              res_store,
    output logic              res_hit,
    output logic [DATA_W-1:0] res_data,
    output logic [TAG_W-1:0]  res_tag,
    output logic              miss_valid
);
    logic              q_full;
    logic              push;
    logic              head_go;
    mem_op_e           head_op;
    logic [DATA_W-1:0] head_bval;
    logic [OFS_W-1:0]  head_ofs;
    logic [TAG_W-1:0]  head_dst;
    logic              issue_take;
    logic              hold;
    mem_op_e           disp_op;

    always_comb begin
        disp_op    = disp_store ? OP_STORE : OP_LOAD;
        push       = disp_valid && !q_full;
        disp_stall = q_full;
    end

    moq_ring #(
        .DEPTH  (DEPTH),
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W),
        .OFS_W  (OFS_W)
    ) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_op   (disp_op),
        .push_btag (disp_base_tag),
        .push_brdy (disp_base_rdy),
        .push_bval (disp_base_val),
        .push_dtag (disp_data_tag),
        .push_drdy (disp_data_rdy),
        .push_ofs  (disp_offset),
        .push_dst  (disp_dst_tag),
        .bc_valid  (bc_valid),
        .bc_tag    (bc_tag),
        .bc_val    (bc_value),
        .pop       (issue_take),
        .full      (q_full),
        .head_go   (head_go),
        .head_op   (head_op),
        .head_bval (head_bval),
        .head_ofs  (head_ofs),
        .head_dst  (head_dst)
    );

    moq_pipe #(
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W),
        .OFS_W  (OFS_W)
    ) u_pipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .iss_req    (head_go),
        .iss_op     (head_op),
        .iss_bval   (head_bval),
        .iss_ofs    (head_ofs),
        .iss_dst    (head_dst),
        .iss_take   (issue_take),
        .hold       (hold),
        .wake_valid (wake_valid),
        .wake_tag   (wake_tag),
        .lk_req     (lk_req),
        .lk_addr    (lk_addr),
        .lk_store   (lk_store),
        .lk_ready   (lk_ready),
        .lk_hit     (lk_hit),
        .lk_data    (lk_data),
        .res_valid  (res_valid),
        .res_store  (res_store),
        .res_hit    (res_hit),
        .res_data   (res_data),
        .res_tag    (res_tag),
        .miss_valid (miss_valid)
    );

endmodule

// File: rtl/mem_order_queue_chk.sv
module mem_order_queue_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              disp_valid,
    input logic              disp_stall,
    input logic              lk_req,
    input logic              lk_ready,
    input logic [DATA_W-1:0] lk_addr,
    input logic              lk_store,
    input logic              wake_valid,
    input logic              res_valid,
    input logic              res_hit,
    input logic              res_store,
    input logic              miss_valid,
    input logic              issue_take,
    input logic              hold
);

    assert_stall_follows_dispatch_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(disp_stall) |-> $past(disp_valid));

    assert_wake_then_lookup_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wake_valid |=> (lk_req && !lk_store));

    assert_result_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(lk_req && lk_ready));

    assert_miss_only_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid |-> (res_valid && !res_hit && !res_store));

    assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && !lk_ready) |=> (lk_req && $stable(lk_addr) && $stable(lk_store)));

    assert_no_issue_in_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> (!issue_take && !wake_valid));

endmodule

bind mem_order_queue mem_order_queue_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/mem_order_queue_bench.sv
module mem_order_queue_bench;
    localparam int DEPTH  = 4;
    localparam int TAG_W  = 4;
    localparam int DATA_W = 16;
    localparam int OFS_W  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic disp_valid = 1'b0, disp_store = 1'b0, disp_base_rdy = 1'b0, disp_data_rdy = 1'b0;
    logic [TAG_W-1:0] disp_base_tag = '0, disp_data_tag = '0, disp_dst_tag = '0;
    logic [DATA_W-1:0] disp_base_val = '0;
    logic [OFS_W-1:0] disp_offset = '0;
    logic disp_stall;
    logic bc_valid = 1'b0;
    logic [TAG_W-1:0] bc_tag = '0;
    logic [DATA_W-1:0] bc_value = '0;
    logic wake_valid;
    logic [TAG_W-1:0] wake_tag;
    logic lk_req, lk_store;
    logic [DATA_W-1:0] lk_addr;
    logic lk_ready = 1'b1, lk_hit = 1'b1;
    logic [DATA_W-1:0] lk_data = '0;
    logic res_valid, res_store, res_hit, miss_valid;
    logic [DATA_W-1:0] res_data;
    logic [TAG_W-1:0] res_tag;

    always #2 clk = ~clk;

    mem_order_queue #(.DEPTH(DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W), .OFS_W(OFS_W))
    u_mem_order_queue (.*);

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] ea(input logic [DATA_W-1:0] b, input logic [OFS_W-1:0] o);
        return b + {{(DATA_W-OFS_W){o[OFS_W-1]}}, o};
    endfunction

    task automatic offer(input logic st, input logic [TAG_W-1:0] btag, input logic brdy,
                         input logic [DATA_W-1:0] bval, input logic [TAG_W-1:0] dtag,
                         input logic drdy, input logic [OFS_W-1:0] ofs, input logic [TAG_W-1:0] dst);
        disp_valid = 1'b1; disp_store = st; disp_base_tag = btag; disp_base_rdy = brdy;
        disp_base_val = bval; disp_data_tag = dtag; disp_data_rdy = drdy;
        disp_offset = ofs; disp_dst_tag = dst;
    endtask

    // collector of completions and lookups
    logic [TAG_W-1:0] got_tag [16];
    logic got_st [16];
    logic [DATA_W-1:0] got_addr [16];
    int n_res, n_addr, n_miss;

    task automatic collect(input int cycles);
        n_res = 0; n_addr = 0; n_miss = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            bc_valid = 1'b0;
            disp_valid = 1'b0;
            if (lk_req && n_addr < 16) begin got_addr[n_addr] = lk_addr; n_addr++; end
            if (res_valid && n_res < 16) begin
                got_tag[n_res] = res_tag; got_st[n_res] = res_store; n_res++;
            end
            if (miss_valid) n_miss++;
        end
    endtask

    typedef struct packed {
        logic              st;
        logic [DATA_W-1:0] base;
        logic [OFS_W-1:0]  ofs;
        logic              hit;
        logic [DATA_W-1:0] data;
        logic [TAG_W-1:0]  dst;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 16'h1234, 8'h10, 1'b1, 16'hCAFE, 4'd3},
        '{1'b0, 16'h0100, 8'hF0, 1'b0, 16'h0000, 4'd4},
        '{1'b1, 16'h8000, 8'h7F, 1'b1, 16'h0000, 4'd5},
        '{1'b0, 16'hFFFF, 8'h02, 1'b1, 16'h5A5A, 4'd6},
        '{1'b1, 16'h0040, 8'h80, 1'b0, 16'h0000, 4'd7},
        '{1'b0, 16'h0000, 8'hFF, 1'b0, 16'h1111, 4'd8}
    };

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(!disp_stall, "R10", "disp_stall", 32'(disp_stall), 0);
        chk(!lk_req && !wake_valid, "R10", "lk_req|wake", 32'({lk_req, wake_valid}), 0);
        chk(!res_valid && !miss_valid, "R10", "res|miss", 32'({res_valid, miss_valid}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: R5 R6 R7 R8
        for (int v = 0; v < 6; v++) begin
            lk_ready = 1'b1; lk_hit = VECS[v].hit; lk_data = VECS[v].data;
            offer(VECS[v].st, 4'd0, 1'b1, VECS[v].base, 4'd0, 1'b1, VECS[v].ofs, VECS[v].dst);
            @(negedge clk);
            disp_valid = 1'b0;
            @(negedge clk);
            chk(wake_valid == !VECS[v].st, "R6", "wake_valid", 32'(wake_valid), 32'(!VECS[v].st));
            if (!VECS[v].st)
                chk(wake_tag == VECS[v].dst, "R6", "wake_tag", 32'(wake_tag), 32'(VECS[v].dst));
            @(negedge clk);
            chk(lk_req && lk_store == VECS[v].st, "R5", "lk_req/store",
                32'({lk_req, lk_store}), 32'({1'b1, VECS[v].st}));
            chk(lk_addr == ea(VECS[v].base, VECS[v].ofs), "R5", "lk_addr",
                32'(lk_addr), 32'(ea(VECS[v].base, VECS[v].ofs)));
            @(negedge clk);
            chk(res_valid && res_tag == VECS[v].dst && res_hit == VECS[v].hit
                && res_store == VECS[v].st, "R7", "res fields",
                32'({res_valid, res_store, res_hit, res_tag}),
                32'({1'b1, VECS[v].st, VECS[v].hit, VECS[v].dst}));
            if (!VECS[v].st)
                chk(res_data == VECS[v].data, "R7", "res_data", 32'(res_data), 32'(VECS[v].data));
            chk(miss_valid == (!VECS[v].st && !VECS[v].hit), "R8", "miss_valid",
                32'(miss_valid), 32'(!VECS[v].st && !VECS[v].hit));
            @(negedge clk);
            chk(!res_valid, "R7", "res pulse one cycle", 32'(res_valid), 0);
        end

        // full queue, dropped dispatch, in-order release: R1 R2 R4
        lk_ready = 1'b1; lk_hit = 1'b1; lk_data = 16'hBEEF;
        offer(1'b0, 4'd1, 1'b0, 16'h0000, 4'd0, 1'b1, 8'h04, 4'd10);
        @(negedge clk);
        offer(1'b0, 4'd0, 1'b1, 16'h2000, 4'd0, 1'b1, 8'h00, 4'd11);
        @(negedge clk);
        offer(1'b1, 4'd0, 1'b1, 16'h3000, 4'd0, 1'b1, 8'h08, 4'd12);
        @(negedge clk);
        offer(1'b0, 4'd0, 1'b1, 16'h4000, 4'd0, 1'b1, 8'h01, 4'd13);
        @(negedge clk);
        chk(disp_stall, "R1", "disp_stall when full", 32'(disp_stall), 1);
        offer(1'b0, 4'd0, 1'b1, 16'h7000, 4'd0, 1'b1, 8'h00, 4'd9);
        @(negedge clk);
        disp_valid = 1'b0;
        begin
            logic seen = 1'b0;
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                if (lk_req || res_valid) seen = 1'b1;
            end
            chk(!seen, "R2", "younger ready ops wait behind blocked head", 32'(seen), 0);
        end
        bc_valid = 1'b1; bc_tag = 4'd1; bc_value = 16'h1000;
        collect(14);
        chk(n_res == 4, "R1", "completions (dropped dispatch absent)", 32'(n_res), 4);
        chk(got_tag[0] == 4'd10 && got_tag[1] == 4'd11 && got_tag[2] == 4'd12 && got_tag[3] == 4'd13,
            "R2", "completion order", 32'({got_tag[0], got_tag[1], got_tag[2], got_tag[3]}), 32'h0000ABCD);
        chk(got_addr[0] == 16'h1004, "R4", "broadcast base captured", 32'(got_addr[0]), 32'h1004);
        chk(got_addr[3] == 16'h4001, "R2", "fourth address", 32'(got_addr[3]), 32'h4001);

        // store waits for data operand: R3, store miss no flag: R8
        lk_hit = 1'b0;
        offer(1'b1, 4'd0, 1'b1, 16'h0500, 4'd5, 1'b0, 8'h00, 4'd14);
        @(negedge clk);
        disp_valid = 1'b0;
        begin
            logic seen = 1'b0;
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                if (lk_req) seen = 1'b1;
            end
            chk(!seen, "R3", "store held for data operand", 32'(seen), 0);
        end
        bc_valid = 1'b1; bc_tag = 4'd5; bc_value = 16'hFFFF;
        collect(8);
        chk(n_res == 1 && got_st[0] && got_tag[0] == 4'd14, "R3", "store issued after data ready",
            32'({n_res[3:0], got_st[0], got_tag[0]}), 32'({4'd1, 1'b1, 4'd14}));
        chk(n_miss == 0, "R8", "store miss raises no miss flag", 32'(n_miss), 0);

        // broadcast in same cycle as dispatch: R4
        lk_hit = 1'b1;
        offer(1'b0, 4'd3, 1'b0, 16'h0000, 4'd0, 1'b1, 8'h10, 4'd15);
        bc_valid = 1'b1; bc_tag = 4'd3; bc_value = 16'h0700;
        collect(8);
        chk(n_addr == 1 && got_addr[0] == 16'h0710, "R4", "same-cycle broadcast address",
            32'(got_addr[0]), 32'h0710);

        // lookup stall holds pipeline: R9, wake resumes: R6
        lk_ready = 1'b0;
        offer(1'b0, 4'd0, 1'b1, 16'h0A00, 4'd0, 1'b1, 8'h00, 4'd1);
        @(negedge clk);
        offer(1'b0, 4'd0, 1'b1, 16'h0B00, 4'd0, 1'b1, 8'h00, 4'd2);
        @(negedge clk);
        disp_valid = 1'b0;
        chk(wake_valid && wake_tag == 4'd1, "R6", "wake first load", 32'({wake_valid, wake_tag}), 32'h11);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(lk_req && lk_addr == 16'h0A00, "R9", "held request", 32'(lk_addr), 32'h0A00);
            chk(!wake_valid && !res_valid, "R9", "no wake/result while held",
                32'({wake_valid, res_valid}), 0);
        end
        lk_ready = 1'b1;
        #1;
        chk(wake_valid && wake_tag == 4'd2, "R6", "wake after release", 32'({wake_valid, wake_tag}), 32'h12);
        @(negedge clk);
        chk(res_valid && res_tag == 4'd1, "R9", "first completes", 32'({res_valid, res_tag}), 32'h11);
        chk(lk_req && lk_addr == 16'h0B00, "R9", "second presented", 32'(lk_addr), 32'h0B00);
        @(negedge clk);
        chk(res_valid && res_tag == 4'd2, "R9", "second completes", 32'({res_valid, res_tag}), 32'h12);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule